// File: doc/BRIEF.md
# Truncating Single-Precision Add/Subtract Unit

This unit adds or subtracts two 32-bit floating-point words and returns one 32-bit word one clock later. It follows a reduced arithmetic model, not IEEE-754. Results are always cut toward zero. No encoding stands for infinity or NaN, so an exponent field of 255 is an ordinary finite exponent. Alignment and normalization keep exactly one bit below the 24-bit significand and discard everything further down. A small zero/sign status travels with every result.

Operands enter on a valid/ready stream and results leave on another. Each accepted pair produces exactly one result. The unit holds a single result register. It accepts a new pair while that register is empty, or in the same cycle that the register's current result is taken by the consumer. While `out_valid` is high and `out_ready` is low, the result word and its flags stay frozen and `in_ready` is low. A producer may keep `in_valid` asserted for any length of time without harm.

Top module: `fadd_rz_unit`

## Requirements
- R1: A word is laid out as sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0, with a hidden leading one for every nonzero exponent.
- R2: When both effective signs match, the magnitudes are added and the result takes that common sign.
- R3: With `in_sub` high, the sign of operand B is inverted before anything else. The result sign is the effective sign of the operand whose exponent and fraction together are larger (operand A on a tie).
- R4: Any bits lost when the significand is renormalized are dropped, so the result magnitude never exceeds the exact magnitude (rounding toward zero).
- R5: The smaller operand's significand is aligned with one extra bit below its lowest fraction bit. Bits shifted past that extra bit are discarded without any sticky bit, and an exponent gap of 25 or more aligns it to zero.
- R6: Exponent value 255 in an operand or a result is an ordinary finite exponent.
- R7: A result exponent above 255 gives exponent 255 and an all-ones fraction, with the result sign kept.
- R8: A nonzero result whose exponent would fall below 1 is output as a zero that carries the result sign.
- R9: A result whose magnitude is exactly zero before the range checks (including exact cancellation and the sum of two zeros) is output as +0 (0x00000000).
- R10: An operand with exponent field 0 counts as zero, whatever its fraction holds.
- R11: A pair accepted on `in_valid && in_ready` appears on `out_valid` at the next clock edge, and `out_valid` is low out of reset.
- R12: While `out_valid` is high and `out_ready` is low, `out_result`, `out_zero` and `out_sign` hold and `in_ready` is low.
- R13: `out_zero` is high exactly when bits 30:0 of the result are zero, and `out_sign` equals bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit can take the pair this cycle |
| in_op_a | input | 32 | Operand A |
| in_op_b | input | 32 | Operand B |
| in_sub | input | 1 | 1 computes A minus B, 0 computes A plus B |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |
| out_zero | output | 1 | Result magnitude is zero |
| out_sign | output | 1 | Result sign bit |

## Verification
The bench goes after the cases where a reduced datapath differs from a full one. A subtraction of a value 25 binades down must leave the larger operand untouched, and a gap of 24 must still borrow through the single extra bit. A design with a sticky bit or a wider alignment would return 0x3F7FFFFF in the first case, and one with no extra bit would return 1.0 in the second. Sums that carry into exponent 255 must stay finite, and one more carry must saturate with the right sign; a design that handles 255 as infinity would give a wrong exponent or fraction. Cancellation must yield +0 while a negative underflow keeps its sign, a stray fraction under a zero exponent must be ignored, and random back-pressure checks that results are neither lost, repeated nor altered while stalled.

// File: rtl/fadd_rz_pkg.sv
package fadd_rz_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;      // significand with hidden one
  localparam int ALN_W  = SIG_W + 1;       // plus one guard position
  localparam int SUM_W  = ALN_W + 1;       // plus carry-out
  localparam int LZ_W   = $clog2(ALN_W);
  localparam int XEXP_W = EXP_W + 2;       // signed exponent with headroom

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fadd_order.sv
// Unpacks both operands, applies the subtract sign flip, orders them by
// magnitude and aligns the smaller significand onto the larger exponent.
module fadd_order
  import fadd_rz_pkg::*;
(
  input  fp_word_t          op_a,
  input  fp_word_t          op_b,
  input  logic              sub,
  output logic              big_sign,
  output logic [EXP_W-1:0]  big_exp,
  output logic [ALN_W-1:0]  big_aln,
  output logic [ALN_W-1:0]  small_aln,
  output logic              eff_sub
);
  localparam logic [EXP_W-1:0] GAP_LIM = EXP_W'(ALN_W);

  logic                  a_nz, b_nz;
  logic                  a_sign, b_sign;
  logic [SIG_W-1:0]      a_sig, b_sig;
  logic [EXP_W+FRAC_W-1:0] a_key, b_key;
  logic                  a_wins;
  logic [EXP_W-1:0]      small_exp;
  logic [SIG_W-1:0]      small_sig;
  logic [SIG_W-1:0]      big_sig;
  logic [EXP_W-1:0]      gap;

  // An exponent field of zero marks a zero operand; its fraction is ignored.
  assign a_nz   = |op_a.exp;
  assign b_nz   = |op_b.exp;
  assign a_sign = op_a.sign;
  assign b_sign = op_b.sign ^ sub;
  assign a_sig  = a_nz ? {1'b1, op_a.frac} : '0;
  assign b_sig  = b_nz ? {1'b1, op_b.frac} : '0;
  assign a_key  = {op_a.exp, a_nz ? op_a.frac : {FRAC_W{1'b0}}};
  assign b_key  = {op_b.exp, b_nz ? op_b.frac : {FRAC_W{1'b0}}};
  assign a_wins = (a_key >= b_key);

  always_comb begin
    if (a_wins) begin
      big_sign  = a_sign;
      big_exp   = op_a.exp;
      big_sig   = a_sig;
      small_exp = op_b.exp;
      small_sig = b_sig;
    end else begin
      big_sign  = b_sign;
      big_exp   = op_b.exp;
      big_sig   = b_sig;
      small_exp = op_a.exp;
      small_sig = a_sig;
    end
  end

  assign gap       = big_exp - small_exp;
  assign big_aln   = {big_sig, 1'b0};
  assign small_aln = (gap >= GAP_LIM) ? '0 : ({small_sig, 1'b0} >> gap);
  assign eff_sub   = a_sign ^ b_sign;
endmodule

// File: rtl/fadd_lzc.sv
// Locates the most significant set bit of a vector.
module fadd_lzc #(
  parameter int W   = 25,
  parameter int P_W = $clog2(W)
) (
  input  logic [W-1:0]   vec,
  output logic [P_W-1:0] pos,
  output logic           any
);
  logic [W:0]   seen;   // seen[i]: some bit at index >= i is set
  logic [W-1:0] first;  // one-hot marker of the leading one

  assign seen[W] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_scan
    assign seen[i]  = seen[i+1] | vec[i];
    assign first[i] = vec[i] & ~seen[i+1];
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) pos = pos | P_W'(i);
    end
  end

  assign any = seen[0];
endmodule

// File: rtl/fadd_norm.sv
// Adds or subtracts the aligned significands, renormalizes by truncation
// and classifies the exponent range.
module fadd_norm
  import fadd_rz_pkg::*;
(
  input  logic              big_sign,
  input  logic [EXP_W-1:0]  big_exp,
  input  logic [ALN_W-1:0]  big_aln,
  input  logic [ALN_W-1:0]  small_aln,
  input  logic              eff_sub,
  output logic              res_sign,
  output logic [EXP_W-1:0]  res_exp,
  output logic [FRAC_W-1:0] res_frac,
  output logic              ovf,
  output logic              unf,
  output logic              zero
);
  localparam logic signed [XEXP_W-1:0] XE_MAX = XEXP_W'((1 << EXP_W) - 1);
  localparam logic signed [XEXP_W-1:0] XE_MIN = XEXP_W'(1);
  localparam logic [LZ_W-1:0]          TOP_POS = LZ_W'(ALN_W - 1);

  logic [SUM_W-1:0]          sum;
  logic                      carry;
  logic [LZ_W-1:0]           lead_pos;
  logic                      lead_any;
  logic [LZ_W-1:0]           lz;
  logic [ALN_W-1:0]          shifted;
  logic signed [XEXP_W-1:0]  xexp;

  assign sum   = eff_sub ? ({1'b0, big_aln} - {1'b0, small_aln})
                         : ({1'b0, big_aln} + {1'b0, small_aln});
  assign carry = sum[SUM_W-1];

  fadd_lzc #(.W(ALN_W), .P_W(LZ_W)) u_lzc (
    .vec (sum[ALN_W-1:0]),
    .pos (lead_pos),
    .any (lead_any)
  );

  assign lz      = TOP_POS - lead_pos;
  assign shifted = sum[ALN_W-1:0] << lz;
  assign zero    = ~carry & ~lead_any;

  always_comb begin
    if (carry) xexp = XEXP_W'(big_exp) + XEXP_W'(1);
    else       xexp = XEXP_W'(big_exp) - XEXP_W'(lz);
  end

  // Carry: drop the two lowest sum bits. Otherwise drop the guard position.
  assign res_frac = carry ? FRAC_W'(sum >> 2) : FRAC_W'(shifted >> 1);
  assign res_exp  = xexp[EXP_W-1:0];
  assign ovf      = ~zero & (xexp > XE_MAX);
  assign unf      = ~zero & (xexp < XE_MIN);
  assign res_sign = zero ? 1'b0 : big_sign;
endmodule

// File: rtl/fadd_rz_unit.sv
module fadd_rz_unit
  import fadd_rz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_op_a,
  input  logic [WORD_W-1:0] in_op_b,
  input  logic              in_sub,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_sign
);
  fp_word_t          op_a, op_b;
  logic              o_sign, o_eff_sub;
  logic [EXP_W-1:0]  o_exp;
  logic [ALN_W-1:0]  o_big, o_small;
  logic              n_sign, n_ovf, n_unf, n_zero;
  logic [EXP_W-1:0]  n_exp;
  logic [FRAC_W-1:0] n_frac;
  logic [WORD_W-1:0] packed_word;
  logic              take;

  assign op_a = fp_word_t'(in_op_a);
  assign op_b = fp_word_t'(in_op_b);

  fadd_order u_order (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub       (in_sub),
    .big_sign  (o_sign),
    .big_exp   (o_exp),
    .big_aln   (o_big),
    .small_aln (o_small),
    .eff_sub   (o_eff_sub)
  );

  fadd_norm u_norm (
    .big_sign  (o_sign),
    .big_exp   (o_exp),
    .big_aln   (o_big),
    .small_aln (o_small),
    .eff_sub   (o_eff_sub),
    .res_sign  (n_sign),
    .res_exp   (n_exp),
    .res_frac  (n_frac),
    .ovf       (n_ovf),
    .unf       (n_unf),
    .zero      (n_zero)
  );

  always_comb begin
    if (n_zero)     packed_word = '0;
    else if (n_unf) packed_word = {n_sign, {(WORD_W-1){1'b0}}};
    else if (n_ovf) packed_word = {n_sign, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
    else            packed_word = {n_sign, n_exp, n_frac};
  end

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_sign   <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= packed_word;
      out_zero   <= n_zero | n_unf;
      out_sign   <= n_sign;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R11: an accepted pair is presented on the next edge
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid)
    else $error("accepted pair did not produce a result");

  // R12: a stalled result is frozen
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                              && $stable(out_zero) && $stable(out_sign))
    else $error("stalled result changed");

  // R13: status flags agree with the result word
  p_zero_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (out_result[WORD_W-2:0] == '0))
    else $error("zero flag disagrees with result");

  p_sign_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sign == out_result[WORD_W-1])
    else $error("sign flag disagrees with result");

  // R7: an overflowing result leaves the unit saturated
  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && n_ovf |=> out_result[WORD_W-2:0] == {(WORD_W-1){1'b1}})
    else $error("overflow did not saturate");

  // R8: an underflowing result leaves the unit as a zero
  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && n_unf |=> out_zero && out_result[WORD_W-2:0] == '0)
    else $error("underflow did not flush");

  // R9: subtracting a word from itself gives +0
  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_sub && (in_op_a == in_op_b) |=> out_result == '0)
    else $error("self-cancel did not give +0");
endmodule

// File: tb/fadd_rz_unit_bench.sv
module fadd_rz_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_op_a = '0;
  logic [31:0] in_op_b = '0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic        out_zero;
  logic        out_sign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rand_mode = 1'b0;
  bit ready_force = 1'b1;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fadd_rz_unit u_fadd_rz_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op_a    (in_op_a),
    .in_op_b    (in_op_b),
    .in_sub     (in_sub),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_zero   (out_zero),
    .out_sign   (out_sign)
  );

  // Consumer readiness changes just after each rising edge.
  initial out_ready = 1'b1;
  always @(posedge clk) begin
    #1;
    out_ready = rand_mode ? (($urandom % 4) != 0) : ready_force;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Independent numeric model of the requirements.
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic s);
    logic sa, sb, bs, ss;
    int ea, eb, be, se, e, d;
    longint ma, mb, bm, sm, ka, kb, r, rs;
    sa = a[31];
    sb = b[31] ^ s;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    ma = (ea == 0) ? 0 : (longint'(a[22:0]) + (longint'(1) << 23));
    mb = (eb == 0) ? 0 : (longint'(b[22:0]) + (longint'(1) << 23));
    ka = longint'(ea) * (longint'(1) << 24) + ma;
    kb = longint'(eb) * (longint'(1) << 24) + mb;
    if (ka >= kb) begin
      bs = sa; be = ea; bm = ma; ss = sb; se = eb; sm = mb;
    end else begin
      bs = sb; be = eb; bm = mb; ss = sa; se = ea; sm = ma;
    end
    d  = be - se;
    rs = (d >= 25) ? 0 : ((sm * 2) >> d);
    r  = bm * 2;
    if (bs == ss) r = r + rs;
    else          r = r - rs;
    if (r == 0) return 32'h0;
    e = be;
    while (r >= (longint'(1) << 25)) begin
      r = r >> 1;
      e++;
    end
    while (r < (longint'(1) << 24)) begin
      r = r * 2;
      e--;
    end
    if (e > 255) return {bs, 8'hFF, 23'h7FFFFF};
    if (e < 1)   return {bs, 31'h0};
    return {bs, e[7:0], r[23:1]};
  endfunction

  task automatic send_exp(input logic [31:0] a, input logic [31:0] b, input logic s,
                          input logic [31:0] expv, input string tag);
    @(negedge clk);
    in_op_a  = a;
    in_op_b  = b;
    in_sub   = s;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                      input string tag);
    send_exp(a, b, s, model(a, b, s), tag);
  endtask

  // Monitor: compares each result as the consumer takes it.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected result", out_result, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_result === e, t, out_result, e);
        check((out_zero === (e[30:0] == 31'h0)) && (out_sign === e[31]),
              {"R13 flags for ", t}, {30'h0, out_zero, out_sign},
              {30'h0, (e[30:0] == 31'h0), e[31]});
      end
    end
  end

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 reset out_valid", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 idle after reset",
          {30'h0, out_valid, in_ready}, 32'h1);

    // Directed cases with hand-computed results
    send_exp(32'h40400000, 32'h3F800000, 1'b0, 32'h40800000, "R1 3+1");
    send_exp(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R2 1+1");
    send_exp(32'h3FC00000, 32'h3E800000, 1'b0, 32'h3FE00000, "R2 1.5+0.25");
    send_exp(32'h40000000, 32'h3F800000, 1'b1, 32'h3F800000, "R3 2-1");
    send_exp(32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, "R3 1-2");
    send_exp(32'h00000000, 32'h3F800000, 1'b1, 32'hBF800000, "R3 0-1");
    send_exp(32'h3F800003, 32'h3F800000, 1'b0, 32'h40000001, "R4 truncate carry");
    send_exp(32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000, "R5 gap 25 no sticky");
    send_exp(32'h3F800000, 32'h33800000, 1'b1, 32'h3F7FFFFF, "R5 gap 24 guard");
    send_exp(32'h7F800000, 32'h7F000000, 1'b1, 32'h7F000000, "R6 exp 255 operand");
    send_exp(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7FFFFFFF, "R6 exp 255 result");
    send_exp(32'hFF800000, 32'hFF800000, 1'b0, 32'hFFFFFFFF, "R7 negative saturate");
    send_exp(32'h80800001, 32'h80800000, 1'b1, 32'h80000000, "R8 negative underflow");
    send_exp(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, "R9 self cancel");
    send_exp(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, "R9 -1+1");
    send_exp(32'h80000000, 32'h80000000, 1'b0, 32'h00000000, "R9 -0+-0");
    send_exp(32'h00000123, 32'h3F800000, 1'b0, 32'h3F800000, "R10 exp0 fraction");

    // Back-pressure: a stalled result holds and blocks new input
    ready_force = 1'b0;
    repeat (2) @(posedge clk);
    send_exp(32'h40A00000, 32'h40400000, 1'b1, 32'h40000000, "R12 stalled 5-3");
    @(negedge clk);
    held = out_result;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b1 && in_ready === 1'b0, "R12 stall handshake",
          {30'h0, out_valid, in_ready}, 32'h2);
    check(out_result === held, "R12 stall hold", out_result, held);
    ready_force = 1'b1;
    repeat (3) @(negedge clk);

    // Random pairs under random back-pressure
    rand_mode = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      int eb;
      a  = $urandom;
      b  = $urandom;
      eb = int'(a[30:23]) + int'($urandom % 9) - 4;
      if (eb < 0)   eb = 0;
      if (eb > 255) eb = 255;
      if ((n % 3) != 0) b[30:23] = eb[7:0];
      if ((n % 17) == 0) b = a;
      send(a, b, n[0], "R2/R3/R4 random");
    end
    rand_mode = 1'b0;
    ready_force = 1'b1;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R11 all results delivered", exp_q.size(), 32'h0);
    report();
  end
endmodule